// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block derives the bit-phase timing for an I2C master from the system clock. A 7-bit baud setting holds a linear divisor field M and an exponent field N. The block emits a one-cycle phase tick every (M+1)·2^(N+1) system clocks. Ten phase ticks make one SCL period, so the bus runs at f_clk / (10·(M+1)·2^(N+1)). The bit sequencer that consumes the ticks uses the phase index to place the SCL edges and the SDA changes.

The divider is built as two stages. The first stage counts M+1 clocks. The second stage counts 2^(N+1) first-stage wraps. A fixed ten-step phase counter follows them. Three events restart every counter from zero: a baud write, a controller soft reset, or the controller being disabled. A new rate therefore always begins with a whole period. Choosing M and N for a target bus speed is left to software.

Top module: `scl_rate_gen`

## Requirements
- R1: The baud setting holds M in bits 6:3 and N in bits 2:0. M ranges over 0..15 and N ranges over 0..7.
- R2: While the generator runs undisturbed, `tick_o` is a single-cycle pulse. It repeats every (M+1)·2^(N+1) clock cycles.
- R3: After `rst_ni` is released, the baud setting is 0x44 (M=8, N=4). The first tick then comes in the 288th enabled cycle.
- R4: A cycle with `soft_rst_i` high restores the baud setting to 0x44 and restarts all counters. No tick is produced in that cycle.
- R5: A cycle with `baud_we_i` high loads `baud_i` and restarts all counters. No tick is produced in that cycle. The first tick at the new rate comes in the P-th cycle after the write, where P=(M+1)·2^(N+1).
- R6: While `en_i` is low, `tick_o` stays low and all counters are held at zero. After `en_i` returns, the first tick comes in the P-th enabled cycle.
- R7: `phase_o` starts at 0 after any restart and advances by one on each tick, wrapping from 9 to 0. `period_o` pulses together with the tick that leaves phase 9, so it marks one SCL period per ten ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable; low holds the generator idle |
| soft_rst_i | input | 1 | Controller soft reset; restores the default baud setting |
| baud_we_i | input | 1 | Baud setting write strobe |
| baud_i | input | 7 | New baud setting: M in bits 6:3, N in bits 2:0 |
| tick_o | output | 1 | Bit-phase tick, ten per SCL period |
| phase_o | output | 4 | Current bit phase, 0..9 |
| period_o | output | 1 | Pulse on the tick that closes an SCL period |

## Verification
The settings are chosen so that each one exposes a different class of fault.
- The fastest setting (both fields zero) runs many full ten-phase periods, which exercises phase wrap and the period pulse.
- The slowest setting (all ones) catches a second-stage counter that is too narrow or an exponent that is off by one.
- A pair of settings with the fields swapped (M=3,N=0 and M=0,N=3) gives periods of 8 and 16. This separates a correct field layout from a transposed one.
- A mid-period rewrite, a disable window and a soft reset show whether each restart clears every stage and whether the default setting comes back.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  localparam int unsigned M_W    = 4;
  localparam int unsigned N_W    = 3;
  localparam int unsigned BAUD_W = M_W + N_W;
  localparam int unsigned POW_W  = 1 << N_W;

  // R1: M occupies the upper field, N the lower
  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } baud_t;
endpackage

// File: rtl/scl_lin_div.sv
module scl_lin_div #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/scl_pow2_div.sv
module scl_pow2_div #(
  parameter int unsigned N_W = 3,
  localparam int unsigned CW = 1 << N_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           step_i,
  input  logic [N_W-1:0] n_i,
  output logic           last_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;

  // terminal count 2^(n+1)-1; a shift by CW yields all ones
  assign mask   = ~({CW{1'b1}} << ({1'b0, n_i} + (N_W+1)'(1)));
  assign last_o = (cnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int unsigned PHASES = 10,
  parameter int unsigned PH_W   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            step_i,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0] ph_q;

  assign phase_o = ph_q;
  assign last_o  = (ph_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (clr_i)  ph_q <= '0;
    else if (step_i) ph_q <= last_o ? '0 : ph_q + PH_W'(1);
  end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int unsigned PHASES   = 10,
  parameter logic [6:0]  BAUD_RST = 7'h44,
  localparam int unsigned PH_W    = $clog2(PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            soft_rst_i,
  input  logic            baud_we_i,
  input  logic [6:0]      baud_i,
  output logic            tick_o,
  output logic [PH_W-1:0] phase_o,
  output logic            period_o
);
  baud_t baud_q;
  logic  run, clr;
  logic  lin_wrap, pow_last, ph_last;

  // R3 R4 R5: baud setting register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         baud_q <= baud_t'(BAUD_RST);
    else if (soft_rst_i) baud_q <= baud_t'(BAUD_RST);
    else if (baud_we_i)  baud_q <= baud_t'(baud_i);
  end

  // R6: any restart source clears every stage
  assign run = en_i & ~soft_rst_i & ~baud_we_i;
  assign clr = ~run;

  scl_lin_div #(.W(M_W)) u_lin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .limit_i (baud_q.m),
    .wrap_o  (lin_wrap)
  );

  scl_pow2_div #(.N_W(N_W)) u_pow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (lin_wrap),
    .n_i    (baud_q.n),
    .last_o (pow_last)
  );

  assign tick_o = run & lin_wrap & pow_last;

  scl_phase_cnt #(.PHASES(PHASES), .PH_W(PH_W)) u_ph (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .step_i  (tick_o),
    .phase_o (phase_o),
    .last_o  (ph_last)
  );

  assign period_o = tick_o & ph_last;
endmodule

// File: rtl/scl_rate_chk.sv
module scl_rate_chk #(
  parameter int unsigned PHASES = 10,
  parameter int unsigned PH_W   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            soft_rst_i,
  input logic            baud_we_i,
  input logic            tick_o,
  input logic [PH_W-1:0] phase_o,
  input logic            period_o
);
  a_r6_no_tick_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);

  a_r5_quiet_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_we_i |=> !tick_o);

  a_r4_quiet_after_soft_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!tick_o && phase_o == '0));

  a_r2_single_cycle_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  a_r7_period_with_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o |-> tick_o);

  a_r7_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < PH_W'(PHASES));

  a_r7_phase_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !soft_rst_i && !baud_we_i && !tick_o) |=> $stable(phase_o));
endmodule

bind scl_rate_gen scl_rate_chk #(.PHASES(PHASES), .PH_W(PH_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .soft_rst_i (soft_rst_i),
  .baud_we_i  (baud_we_i),
  .tick_o     (tick_o),
  .phase_o    (phase_o),
  .period_o   (period_o)
);

// File: tb/scl_rate_gen_tb.sv
`timescale 1ns/1ps
module scl_rate_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       baud_we_i = 1'b0;
  logic [6:0] baud_i = '0;
  logic       tick_o;
  logic [3:0] phase_o;
  logic       period_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference model state
  int m_baud = 'h44;
  int m_cnt  = 0;
  int m_ph   = 0;

  always #2.5 clk_i = ~clk_i;

  scl_rate_gen dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .soft_rst_i (soft_rst_i),
    .baud_we_i  (baud_we_i),
    .baud_i     (baud_i),
    .tick_o     (tick_o),
    .phase_o    (phase_o),
    .period_o   (period_o)
  );

  // R1: M = bits 6:3, N = bits 2:0; P = (M+1)*2^(N+1)
  function automatic int per_of(input int b);
    return (((b >> 3) & 15) + 1) * (2 << (b & 7));
  endfunction

  task automatic step(input bit en, input bit srst, input bit we,
                      input logic [6:0] b, input string tag);
    bit run, e_tick, e_per;
    en_i = en; soft_rst_i = srst; baud_we_i = we; baud_i = b;
    #1;
    run    = en && !srst && !we;
    e_tick = run && (m_cnt == per_of(m_baud) - 1);
    e_per  = e_tick && (m_ph == 9);
    vectors++;
    if (tick_o !== e_tick || phase_o !== 4'(m_ph) || period_o !== e_per) begin
      errors++;
      $display("FAIL %s: tick/phase/period = %0b/%0d/%0b expected %0b/%0d/%0b",
               tag, tick_o, phase_o, period_o, e_tick, m_ph, e_per);
    end
    if (srst)    m_baud = 'h44;
    else if (we) m_baud = int'(b);
    if (!run) begin
      m_cnt = 0; m_ph = 0;
    end else if (e_tick) begin
      m_cnt = 0; m_ph = (m_ph == 9) ? 0 : m_ph + 1;
    end else begin
      m_cnt++;
    end
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_en(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 7'h00, tag);
  endtask

  task automatic write_baud(input logic [6:0] b, input string tag);
    step(1'b1, 1'b0, 1'b1, b, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // reset state: outputs idle while rst_ni is low (R7)
    en_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    vectors++;
    if (tick_o !== 1'b0 || phase_o !== 4'd0 || period_o !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset: tick/phase/period = %0b/%0d/%0b expected 0/0/0",
               tick_o, phase_o, period_o);
    end
    rst_ni = 1'b1;
    // R3: default 0x44 -> 288 cycles per tick
    run_en(3 * 288 + 5, "R3");
    // R2 R7: fastest setting, many full periods
    write_baud(7'h00, "R5");
    run_en(70, "R7");
    // R1: swapped fields give different periods (8 vs 16)
    write_baud(7'h18, "R1");
    run_en(50, "R1");
    write_baud(7'h03, "R1");
    run_en(70, "R1");
    // R2: slowest setting
    write_baud(7'h7F, "R2");
    run_en(2 * 4096 + 3, "R2");
    // R5: rewrite mid-period
    write_baud(7'h2A, "R5");
    run_en(70, "R2");
    write_baud(7'h18, "R5");
    run_en(40, "R5");
    // R6: disable window, then resume
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 1'b0, 7'h00, "R6");
    run_en(100, "R6");
    // R6: disabled cycle coinciding with a write
    step(1'b0, 1'b0, 1'b1, 7'h08, "R6");
    run_en(40, "R6");
    // R4: soft reset restores the default
    step(1'b1, 1'b1, 1'b0, 7'h00, "R4");
    run_en(2 * 288 + 5, "R4");
    // R4: soft reset wins over a simultaneous write
    step(1'b1, 1'b1, 1'b1, 7'h00, "R4");
    run_en(300, "R4");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule